// File: doc/BRIEF.md
# Programmable Interval Timer with Reload

This block is a byte-wide, memory-mapped interval timer for a small 8-bit system running from a 4.194304 MHz clock. A single 16-bit divider counts every clock cycle without stopping. Its upper byte is visible to the CPU as a divider register, and any write to that register clears the whole divider. An 8-bit up-counter advances once per period of a rate chosen from four power-of-two taps of the divider. Counting is gated by a start bit in the control register.

When the counter steps past 0xFF it does not wrap to zero. It loads the value held in a separate reload register, and the block emits a one-cycle timer request pulse for the interrupt logic that sits outside it. Software sets the interval by choosing the rate and the reload value. A CPU write to the counter always takes precedence over a reload that falls in the same cycle.

Top module: `prog_timer`

## Requirements
- R1: While reset is held, all four registers read 0x00 and the request output is low.
- R2: Address 0 reads the upper 8 bits of the 16-bit divider. That value rises by one every 256 clock cycles.
- R3: Any write to address 0 clears the full 16-bit divider, whatever the data written.
- R4: When control bit 2 (start) is 0, the counter at address 1 keeps its value.
- R5: With start set, control bits 1:0 pick the counting period. Code 00 gives 1024 cycles, 01 gives 16, 10 gives 64 and 11 gives 256. After a divider clear at edge E, the first increment lands at edge E + period.
- R6: A step from 0xFF loads the counter with the value at address 2 at that same edge, so 0x00 is never seen.
- R7: The request output is high for exactly one cycle, in the cycle that follows each reload edge, and at no other time.
- R8: A CPU write to the counter at the edge where an overflow would happen wins. The counter takes the written data, there is no reload and no request pulse.
- R9: The reload register at address 2 reads back what was written. The control register at address 3 reads back bits 2:0, and bits 7:3 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 2 | Register select: 0 divider, 1 counter, 2 reload, 3 control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq_pulse | output | 1 | One-cycle timer request on overflow |

## Verification
The embedded assertions check these on every cycle:
- the divider steps by one and clears on a write;
- the counter holds while stopped;
- the counter steps by one on a tick;
- a reload carries the earlier reload value;
- the request pulse lasts one cycle;
- a CPU write beats an overflow.

Only the bench scenarios can show that each rate code gives the right period measured from a divider clear. They also show that the divider reads its upper byte at the right edges and that control bits read back masked. The exact edge on which an overflow write races a tick is likewise shown only by those scenarios.

// File: rtl/tmr_pkg.sv
// Package: shared parameters, register addresses and rate-tap mapping for
// the programmable interval timer. Assumes a 2-bit register address.
package tmr_pkg;

    localparam int ADDR_W = 2;
    localparam int CTRL_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIV  = 2'd0,
        REG_CNT  = 2'd1,
        REG_LOAD = 2'd2,
        REG_CTRL = 2'd3
    } reg_addr_e;

    localparam int START_BIT = 2;
    localparam int RATE_W    = 2;
    localparam int NUM_RATES = 1 << RATE_W;

    // Number of low divider bits that must all be one for a tick at each rate code
    function automatic int rate_shift(input int code);
        case (code)
            0:       return 10;
            1:       return 4;
            2:       return 6;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/tmr_divider.sv
// Module: free-running divider. Counts up once per clock and is cleared to
// zero at the edge of any CPU write to it. Assumes DIV_W >= 11 so that every
// rate tap exists.
module tmr_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [DIV_W-1:0] div_q
);

    // Divider register: reset, clear on write, otherwise increment
    always_ff @(posedge clk) begin
        if (!rst_n)   div_q <= '0;
        else if (clr) div_q <= '0;
        else          div_q <= div_q + 1'b1;
    end

    p_div_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> div_q == '0);

    p_div_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> div_q == $past(div_q) + 1'b1);

endmodule

// File: rtl/tmr_prescale.sv
// Module: rate selector. Raises a one-cycle tick when the low bits of the
// divider for the selected rate are all ones, so that the counter steps at the
// same edge where that divider tap rolls over. No tick is produced while
// stopped or while the divider is being cleared.
module tmr_prescale #(
    parameter int DIV_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DIV_W-1:0]         div_q,
    input  logic [tmr_pkg::RATE_W-1:0] rate,
    input  logic                     start,
    input  logic                     div_clr,
    output logic                     tick
);
    import tmr_pkg::*;

    logic [NUM_RATES-1:0] tap_full;

    // One all-ones detector per rate code
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
        localparam int SH = rate_shift(g);
        localparam logic [DIV_W-1:0] MASK = (DIV_W'(1) << SH) - 1'b1;
        assign tap_full[g] = (div_q & MASK) == MASK;
    end

    // Tick: selected tap full, running, and the divider is not being cleared
    always_comb begin
        tick = start && tap_full[rate] && !div_clr;
    end

    p_tick_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> !tick);

endmodule

// File: rtl/tmr_counter.sv
// Module: counter, reload and control registers. On a tick the counter steps.
// A step from all-ones loads the reload value and raises a registered
// one-cycle request. A CPU write to the counter wins over any tick in the same
// cycle.
module tmr_counter #(
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       cnt_we,
    input  logic                       load_we,
    input  logic                       ctrl_we,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          cnt_q,
    output logic [DATA_W-1:0]          load_q,
    output logic [tmr_pkg::CTRL_W-1:0] ctrl_q,
    output logic                       irq_q
);
    import tmr_pkg::*;

    logic [DATA_W-1:0] cnt_d;
    logic              irq_d;

    // Next counter value and request, with CPU write taking priority
    always_comb begin
        cnt_d = cnt_q;
        irq_d = 1'b0;
        if (cnt_we) begin
            cnt_d = wdata;
        end else if (tick) begin
            if (cnt_q == '1) begin
                cnt_d = load_q;
                irq_d = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // Counter and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq_q <= irq_d;
        end
    end

    // Reload and control registers, written directly by the CPU
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (load_we) load_q <= wdata;
            if (ctrl_we) ctrl_q <= wdata[CTRL_W-1:0];
        end
    end

    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[START_BIT] && !cnt_we) |=> cnt_q == $past(cnt_q));

    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 1'b1);

    p_reload_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we && cnt_q == '1) |=> cnt_q == $past(load_q));

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(cnt_q) == '1);

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_q == $past(wdata) && !irq_q));

endmodule

// File: rtl/prog_timer.sv
// Module: top of the programmable interval timer. Decodes CPU writes into
// per-register strobes, connects divider, rate selector and counter, and
// drives a combinational read mux from the address. Assumes reads have no
// side effects.
module prog_timer #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [tmr_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       irq_pulse
);
    import tmr_pkg::*;

    localparam int DIV_TOP = DIV_W - 1;

    logic                 div_we, cnt_we, load_we, ctrl_we;
    logic [DIV_W-1:0]     div_q;
    logic [DATA_W-1:0]    cnt_q, load_q;
    logic [CTRL_W-1:0]    ctrl_q;
    logic                 tick;

    // Write strobe decode
    always_comb begin
        div_we  = wr_en && (addr == REG_DIV);
        cnt_we  = wr_en && (addr == REG_CNT);
        load_we = wr_en && (addr == REG_LOAD);
        ctrl_we = wr_en && (addr == REG_CTRL);
    end

    tmr_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_we),
        .div_q (div_q)
    );

    tmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_q   (div_q),
        .rate    (ctrl_q[RATE_W-1:0]),
        .start   (ctrl_q[START_BIT]),
        .div_clr (div_we),
        .tick    (tick)
    );

    tmr_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt_we  (cnt_we),
        .load_we (load_we),
        .ctrl_we (ctrl_we),
        .wdata   (wr_data),
        .cnt_q   (cnt_q),
        .load_q  (load_q),
        .ctrl_q  (ctrl_q),
        .irq_q   (irq_pulse)
    );

    // Combinational read mux
    always_comb begin
        case (addr)
            REG_DIV:  rd_data = div_q[DIV_TOP -: DATA_W];
            REG_CNT:  rd_data = cnt_q;
            REG_LOAD: rd_data = load_q;
            default:  rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        endcase
    end

    p_irq_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !irq_pulse);

endmodule

// File: tb/prog_timer_tb.sv
// Scoreboard bench: driver tasks push expected read items into a queue and a
// monitor pops and compares each against rd_data.
module prog_timer_tb_top;

    localparam time CLK_HALF = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq_pulse;

    int total = 0;
    int bad = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] exp;
    } item_t;

    item_t sb_q[$];
    event  mon_ev;

    always #CLK_HALF clk = ~clk;

    prog_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse)
    );

    // Count request cycles away from the active edge
    always @(negedge clk) if (rst_n && irq_pulse) irq_seen++;

    // Monitor: pop and compare each expected item
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (rd_data !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got %h expected %h", it.req, rd_data, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input string req);
        item_t it;
        addr = a;
        #1;
        it.req = req;
        it.exp = e;
        sb_q.push_back(it);
        ->mon_ev;
        #1;
    endtask

    task automatic check_val(input int got, input int exp, input string req);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr = a;
        wr_data = d;
        @(posedge clk);
        #2;
        wr_en = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Measure one rate: start from count 0, clear divider, check before and at the period
    task automatic rate_case(input logic [1:0] code, input int period, input string req);
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd3, {5'd0, 1'b1, code});
        wr(2'd0, 8'h5A);
        wait_edges(period - 1);
        expect_rd(2'd1, 8'h00, req);
        wait_edges(1);
        expect_rd(2'd1, 8'h01, req);
        wait_edges(period);
        expect_rd(2'd1, 8'h02, req);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #(CLK_HALF * 2 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int irq_before;
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        expect_rd(2'd0, 8'h00, "R1 divider");
        expect_rd(2'd1, 8'h00, "R1 counter");
        expect_rd(2'd2, 8'h00, "R1 reload");
        expect_rd(2'd3, 8'h00, "R1 control");
        check_val(int'(irq_pulse), 0, "R1 irq");
        @(negedge clk);
        rst_n = 1'b1;

        // R9: readback of reload and masked control
        wr(2'd2, 8'hA5);
        expect_rd(2'd2, 8'hA5, "R9 reload");
        wr(2'd3, 8'hF8);
        expect_rd(2'd3, 8'h00, "R9 control upper bits");
        wr(2'd3, 8'h03);
        expect_rd(2'd3, 8'h03, "R9 control low bits");

        // R2/R3: divider upper byte after a clear with nonzero data
        wr(2'd0, 8'hFF);
        wait_edges(3 * 256 - 1);
        expect_rd(2'd0, 8'h02, "R2 divider before step");
        wait_edges(1);
        expect_rd(2'd0, 8'h03, "R2 divider after step");
        wr(2'd0, 8'h37);
        expect_rd(2'd0, 8'h00, "R3 divider cleared");

        // R4: stopped counter holds across many cycles
        wr(2'd3, 8'h01);
        wr(2'd1, 8'h42);
        wait_edges(300);
        expect_rd(2'd1, 8'h42, "R4 hold while stopped");

        // R5: each rate code
        rate_case(2'b01, 16, "R5 code01");
        rate_case(2'b10, 64, "R5 code10");
        rate_case(2'b11, 256, "R5 code11");
        rate_case(2'b00, 1024, "R5 code00");

        // R6/R7: overflow reloads and pulses once
        wr(2'd3, 8'h00);
        wr(2'd1, 8'hFE);
        wr(2'd2, 8'h40);
        wr(2'd3, 8'h05);
        irq_before = irq_seen;
        wr(2'd0, 8'h00);
        wait_edges(16);
        expect_rd(2'd1, 8'hFF, "R6 at FF");
        check_val(int'(irq_pulse), 0, "R7 no irq before overflow");
        wait_edges(16);
        expect_rd(2'd1, 8'h40, "R6 reload value");
        check_val(int'(irq_pulse), 1, "R7 irq in reload cycle");
        wait_edges(1);
        check_val(int'(irq_pulse), 0, "R7 irq drops after one cycle");
        check_val(irq_seen - irq_before, 1, "R7 single pulse");

        // R8: CPU write at the overflow edge wins
        wr(2'd3, 8'h00);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h77);
        wr(2'd3, 8'h05);
        wr(2'd0, 8'h00);
        irq_before = irq_seen;
        repeat (15) @(posedge clk);
        wr(2'd1, 8'h10);
        expect_rd(2'd1, 8'h10, "R8 write wins");
        wait_edges(4);
        check_val(irq_seen - irq_before, 0, "R8 no pulse");
        wr(2'd3, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule